// File: doc/BRIEF.md
# Double-Edge Pixel Bus Unpacker

This block receives pixels on a narrow parallel bus that carries one half of each transfer before the falling clock edge and the other half before the rising edge. It rebuilds complete pixels as three 8-bit components: red or Cr, green or luma, and blue or Cb. With each pixel it raises a one-cycle valid strobe. A 2-bit mode input picks one of four packings:
- mode 0: 24-bit 4:4:4 on a 12-bit bus.
- mode 1: 15-bit RGB on an 8-bit bus.
- mode 2: 16-bit RGB on an 8-bit bus.
- mode 3: 4:2:2 luma/chroma, in which a group of four bytes spread over two clocks gives two pixels that share one chroma pair.

Each clock period starts with its falling-edge half and ends with its rising edge. The block latches the falling half in a negative-edge register. It joins that half with the rising half at the rising edge, and the pixel appears on registered outputs after that edge. A line-start pulse, sampled at a rising edge, loads the requested mode and aligns the 4:2:2 phase to the start of a group. RGB components narrower than 8 bits are placed at the top of the byte, and their own top bits fill the low bits.

Top module: `dualedge_pixel_unpack`

## Requirements
- R1: While reset is asserted (rstN low), pixValid and all three components are 0. After reset the active mode is 0 and the 4:2:2 phase is at the start of a group.
- R2: In mode 0, the falling half gives blue[7:0] on bus[7:0] and green[3:0] on bus[11:8]. The rising half gives green[7:4] on bus[3:0] and red[7:0] on bus[11:4].
- R3: In mode 1, the falling half gives green[2:0] on bus[7:5] and blue[4:0] on bus[4:0]. The rising half gives red[4:0] on bus[6:2] and green[4:3] on bus[1:0]. Rising-half bus[7] has no effect. Each 5-bit value c is output as {c, c[4:2]}.
- R4: In mode 2, the falling half is the same as in mode 1. The rising half gives red[4:0] on bus[7:3] and green[5:3] on bus[2:0]. Red and blue are output as {c, c[4:2]} and green as {g, g[5:4]}.
- R5: In modes 0 to 2, every rising edge without line-start produces a pixel built from the falling half just before it and the rising half at it. The pixel appears with pixValid high after that edge.
- R6: In mode 3, bus[7:0] carries Cb at the falling half of clock n, Y0 at the rising half of n, Cr at the falling half of n+1 and Y1 at the rising half of n+1. No pixel follows the edge of clock n. After the edge of clock n+1, the output is (Cr, Y0, Cb) with pixValid high.
- R7: In mode 3, the second pixel of a group, (Cr, Y1, Cb) with the same Cb and Cr, appears with pixValid high after the edge of the following clock. That edge also takes in the falling and rising halves of the next group.
- R8: The mode input is taken only at a rising edge where line-start is high. That edge produces no pixel and discards any second pixel of a group that has not yet been output.
- R9: In modes 1, 2 and 3, bus[11:8] has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; both edges carry data |
| rstN | input | 1 | Asynchronous reset, active low |
| lineStart | input | 1 | Loads the mode and restarts the 4:2:2 phase at this rising edge |
| fmtSel | input | 2 | Requested packing mode, 0 to 3 |
| busIn | input | 12 | Double-edge pixel data bus |
| pixValid | output | 1 | High for one cycle per output pixel |
| compR | output | 8 | Red or Cr component |
| compG | output | 8 | Green or luma component |
| compB | output | 8 | Blue or Cb component |

## Verification
The assertions assume that reset is held for at least one full clock and that line-start is a synchronous pulse sampled only at rising edges. They also assume that the bus settles before each edge it is sampled on, so every falling half is complete before the rising edge that uses it. The bench meets these assumptions by changing the bus and control inputs one time unit after an edge, never at an edge. In 4:2:2 runs it sends whole groups, except in one case where it starts a new line in the middle of a group to show that the pending pixel is dropped.

// File: rtl/dvin_pkg.sv
package dvin_pkg;
  localparam int BUS_W  = 12;
  localparam int BYTE_W = 8;
  localparam int COMP_W = 8;
  localparam int NIB_W  = BUS_W - BYTE_W;

  typedef enum logic [1:0] {
    FMT_RGB24  = 2'd0,
    FMT_RGB555 = 2'd1,
    FMT_RGB565 = 2'd2,
    FMT_YC422  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic emitWide;
    logic grabLead;
    logic emitFirst;
    logic emitSecond;
  } strobe_t;
endpackage

// File: rtl/dvin_ctrl.sv
module dvin_ctrl
  import dvin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineStart,
  input  logic [1:0] fmtSel,
  output fmt_e       activeFmt,
  output logic       phase,
  output strobe_t    stb
);
  logic pending;

  always_comb begin
    stb = '0;
    if (!lineStart) begin
      if (activeFmt != FMT_YC422) begin
        stb.emitWide = 1'b1;
      end else if (!phase) begin
        stb.grabLead   = 1'b1;
        stb.emitSecond = pending;
      end else begin
        stb.emitFirst = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeFmt <= FMT_RGB24;
      phase     <= 1'b0;
      pending   <= 1'b0;
    end else if (lineStart) begin
      activeFmt <= fmt_e'(fmtSel);
      phase     <= 1'b0;
      pending   <= 1'b0;
    end else if (activeFmt == FMT_YC422) begin
      phase   <= ~phase;
      pending <= phase;
    end else begin
      phase   <= 1'b0;
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dvin_path.sv
module dvin_path
  import dvin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  busIn,
  input  fmt_e              activeFmt,
  input  strobe_t           stb,
  output logic              pixValid,
  output logic [COMP_W-1:0] compR,
  output logic [COMP_W-1:0] compG,
  output logic [COMP_W-1:0] compB
);
  logic [BUS_W-1:0]  fallWord;
  logic [COMP_W-1:0] wideR, wideG, wideB;
  logic [BYTE_W-1:0] cbHold, y0Hold, crHold, y1Hold;

  function automatic logic [COMP_W-1:0] grow5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [COMP_W-1:0] grow6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallWord <= '0;
    else       fallWord <= busIn;
  end

  always_comb begin
    wideR = '0;
    wideG = '0;
    wideB = '0;
    unique case (activeFmt)
      FMT_RGB24: begin
        wideB = fallWord[BYTE_W-1:0];
        wideG = {busIn[NIB_W-1:0], fallWord[BUS_W-1:BYTE_W]};
        wideR = busIn[BUS_W-1:NIB_W];
      end
      FMT_RGB555: begin
        wideB = grow5(fallWord[4:0]);
        wideG = grow5({busIn[1:0], fallWord[7:5]});
        wideR = grow5(busIn[6:2]);
      end
      FMT_RGB565: begin
        wideB = grow5(fallWord[4:0]);
        wideG = grow6({busIn[2:0], fallWord[7:5]});
        wideR = grow5(busIn[7:3]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cbHold <= '0;
      y0Hold <= '0;
      crHold <= '0;
      y1Hold <= '0;
    end else begin
      if (stb.grabLead) begin
        cbHold <= fallWord[BYTE_W-1:0];
        y0Hold <= busIn[BYTE_W-1:0];
      end
      if (stb.emitFirst) begin
        crHold <= fallWord[BYTE_W-1:0];
        y1Hold <= busIn[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      compR    <= '0;
      compG    <= '0;
      compB    <= '0;
    end else begin
      pixValid <= stb.emitWide | stb.emitFirst | stb.emitSecond;
      if (stb.emitWide) begin
        compR <= wideR;
        compG <= wideG;
        compB <= wideB;
      end else if (stb.emitFirst) begin
        compR <= fallWord[BYTE_W-1:0];
        compG <= y0Hold;
        compB <= cbHold;
      end else if (stb.emitSecond) begin
        compR <= crHold;
        compG <= y1Hold;
        compB <= cbHold;
      end
    end
  end
endmodule

// File: rtl/dualedge_pixel_unpack.sv
module dualedge_pixel_unpack
  import dvin_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineStart,
  input  logic [1:0]  fmtSel,
  input  logic [11:0] busIn,
  output logic        pixValid,
  output logic [7:0]  compR,
  output logic [7:0]  compG,
  output logic [7:0]  compB
);
  fmt_e    activeFmt;
  logic    phase;
  strobe_t stb;

  dvin_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .lineStart (lineStart),
    .fmtSel    (fmtSel),
    .activeFmt (activeFmt),
    .phase     (phase),
    .stb       (stb)
  );

  dvin_path path_i (
    .clk       (clk),
    .rstN      (rstN),
    .busIn     (busIn),
    .activeFmt (activeFmt),
    .stb       (stb),
    .pixValid  (pixValid),
    .compR     (compR),
    .compG     (compG),
    .compB     (compB)
  );
endmodule

// File: rtl/dvin_chk.sv
module dvin_chk (
  input logic       clk,
  input logic       rstN,
  input logic       lineStart,
  input logic [1:0] fmtSel,
  input logic [1:0] activeFmt,
  input logic       phase,
  input logic       pixValid,
  input logic [7:0] compR,
  input logic [7:0] compG,
  input logic [7:0] compB
);
  // R8
  line_start_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> !pixValid);

  // R8
  fmt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> activeFmt == $past(fmtSel));

  // R5
  wide_every_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lineStart && activeFmt != 2'd3) |=> pixValid);

  // R3
  rgb555_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && activeFmt == 2'd1) |->
      (compR[2:0] == compR[7:5] && compG[2:0] == compG[7:5] && compB[2:0] == compB[7:5]));

  // R4
  rgb565_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && activeFmt == 2'd2) |->
      (compR[2:0] == compR[7:5] && compG[1:0] == compG[7:6] && compB[2:0] == compB[7:5]));

  // R7
  shared_chroma_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && activeFmt == 2'd3 && phase) |->
      ($past(pixValid) && compR == $past(compR) && compB == $past(compB)));
endmodule

bind dualedge_pixel_unpack dvin_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .lineStart (lineStart),
  .fmtSel    (fmtSel),
  .activeFmt (activeFmt),
  .phase     (phase),
  .pixValid  (pixValid),
  .compR     (compR),
  .compG     (compG),
  .compB     (compB)
);

// File: tb/dualedge_pixel_unpack_tb_top.sv
module dualedge_pixel_unpack_tb_top;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0;
  logic [1:0]  fmtSel = 2'd0;
  logic [11:0] busIn = '0;
  logic        pixValid;
  logic [7:0]  compR, compG, compB;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_T/2) clk = ~clk;

  dualedge_pixel_unpack dut_i (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .fmtSel(fmtSel),
    .busIn(busIn), .pixValid(pixValid), .compR(compR), .compG(compG), .compB(compB)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  function automatic logic [7:0] w5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [7:0] w6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  // Called just after a rising edge; returns just after the next rising edge.
  task automatic step(input logic [11:0] fallW, input logic [11:0] riseW, input logic ls);
    busIn = fallW;
    @(negedge clk);
    #1;
    busIn = riseW;
    lineStart = ls;
    @(posedge clk);
    #1;
    lineStart = 1'b0;
  endtask

  task automatic expectPix(input string req, input logic v,
                           input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    nChecks++;
    if (pixValid !== v || (v && (compR !== r || compG !== g || compB !== b))) begin
      nErrors++;
      $display("FAIL %s: got v=%0b r=%02h g=%02h b=%02h expected v=%0b r=%02h g=%02h b=%02h",
               req, pixValid, compR, compG, compB, v, r, g, b);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 200000);
    nErrors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] r8, g8, b8;
    logic [4:0] r5, b5;
    logic [5:0] g6;
    logic [7:0] cb, y0, cr, y1, pcb, pcr, py1;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    nChecks++;
    if (pixValid !== 1'b0 || compR !== 8'h00 || compG !== 8'h00 || compB !== 8'h00) begin
      nErrors++;
      $display("FAIL R1: got v=%0b r=%02h g=%02h b=%02h expected all zero",
               pixValid, compR, compG, compB);
    end
    rstN = 1'b1;
    fmtSel = 2'd2;
    // R1/R8: mode 0 active after reset despite fmtSel=2
    step(12'h5A3, 12'hC7E, 1'b0);
    expectPix("R1 R8 default mode 0", 1'b1, 8'hC7, 8'hE5, 8'hA3);

    // R2 R5: mode 0 sweep
    fmtSel = 2'd0;
    step(12'h000, 12'h000, 1'b1);
    expectPix("R8 line start quiet", 1'b0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      seed = nextRand(seed);
      r8 = seed[31:24]; g8 = seed[23:16]; b8 = seed[15:8];
      step({g8[3:0], b8}, {r8, g8[7:4]}, 1'b0);
      expectPix("R2 R5 mode 0", 1'b1, r8, g8, b8);
    end

    // R3 R9: mode 1 sweep over 15-bit values
    fmtSel = 2'd1;
    step(12'h000, 12'h000, 1'b1);
    expectPix("R8 line start quiet", 1'b0, 0, 0, 0);
    for (int p = 0; p < 32768; p += 5) begin
      seed = nextRand(seed);
      r5 = p[14:10]; g6 = {1'b0, p[9:5]}; b5 = p[4:0];
      step({seed[11:8], g6[2:0], b5}, {seed[15:12], seed[16], r5, g6[4:3]}, 1'b0);
      expectPix("R3 R9 mode 1", 1'b1, w5(r5), w5(g6[4:0]), w5(b5));
    end

    // R4 R9 R8: mode 2 sweep over 16-bit values, fmtSel wanders
    fmtSel = 2'd2;
    step(12'h000, 12'h000, 1'b1);
    expectPix("R8 line start quiet", 1'b0, 0, 0, 0);
    for (int p = 0; p < 65536; p += 5) begin
      seed = nextRand(seed);
      fmtSel = seed[21:20];
      r5 = p[15:11]; g6 = p[10:5]; b5 = p[4:0];
      step({seed[11:8], g6[2:0], b5}, {seed[15:12], r5, g6[5:3]}, 1'b0);
      expectPix("R4 R8 R9 mode 2", 1'b1, w5(r5), w6(g6), w5(b5));
    end

    // R6 R7 R8 R9: mode 3 groups
    fmtSel = 2'd3;
    step(12'h000, 12'h000, 1'b1);
    expectPix("R8 line start quiet", 1'b0, 0, 0, 0);
    pcb = 0; pcr = 0; py1 = 0;
    for (int grp = 0; grp < 1500; grp++) begin
      seed = nextRand(seed);
      cb = seed[31:24]; y0 = seed[23:16]; cr = seed[15:8]; y1 = seed[7:0];
      fmtSel = seed[5:4];
      step({seed[19:16], cb}, {seed[27:24], y0}, 1'b0);
      if (grp == 0) expectPix("R6 no pixel after lead half", 1'b0, 0, 0, 0);
      else          expectPix("R7 second pixel", 1'b1, pcr, py1, pcb);
      step({seed[11:8], cr}, {seed[3:0], y1}, 1'b0);
      expectPix("R6 first pixel", 1'b1, cr, y0, cb);
      pcb = cb; pcr = cr; py1 = y1;
    end
    // R8: line start discards the pending second pixel
    fmtSel = 2'd3;
    step(12'h000, 12'h000, 1'b1);
    expectPix("R8 pending dropped", 1'b0, 0, 0, 0);
    step(12'h0AB, 12'h0CD, 1'b0);
    expectPix("R6 R8 restart lead half", 1'b0, 0, 0, 0);
    // R8: restart in the middle of a group
    step(12'h000, 12'h000, 1'b1);
    expectPix("R8 mid-group restart", 1'b0, 0, 0, 0);
    step(12'h011, 12'h022, 1'b0);
    expectPix("R6 lead half after restart", 1'b0, 0, 0, 0);
    step(12'hF33, 12'hF44, 1'b0);
    expectPix("R6 R9 first pixel after restart", 1'b1, 8'h33, 8'h22, 8'h11);
    step(12'h055, 12'h066, 1'b0);
    expectPix("R7 second pixel after restart", 1'b1, 8'h33, 8'h44, 8'h11);

    finishRun();
  end
endmodule